// File: doc/BRIEF.md
# Receive Packet Release and Aging Checker

This block sits beside an isochronous receive buffer and judges the packet at the head of that buffer. Each head packet carries a captured 25-bit bus time stamp. The block compares this stamp with the free-running bus cycle time. Once the cycle time has reached the stamp, the block marks the packet readable. It also adds a programmable receive offset to the stamp to form a deadline. If the cycle time moves strictly past that deadline while the packet is still unread, the block issues a one-clock discard request to the buffer.

Both the stamp and the cycle time use a mixed-radix format: a 13-bit cycle count in bits 24:12 (0 to 7999) and a 12-bit tick offset in bits 11:0 (0 to 3071). The stamp-plus-offset sum carries at those limits. The whole timer wraps every 8000 cycles. For that reason, every ordering between two times is decided modulo the full period: a time is "at or after" another when it lies less than half a period ahead of it. The buffer presents a packet with `pkt_valid` and consumes it with `pkt_read`. A discard request also counts as consuming the head packet, so the state is judged afresh in the next clock.

Top module: `rxage_guard`

## Requirements
- R1: One clock after a clock with `pkt_valid` high and `cycle_time` equal to `rx_stamp` or up to half a timer period (12,288,000 ticks) after it, `pkt_release` is high. It stays high while the same packet is held. A stamp that is more than half a period ahead reads as not yet reached.
- R2: The deadline is `rx_stamp` + `rx_offset` in the mixed-radix format. Ticks (bits 11:0) carry into the count at 3072, and the count (bits 24:12) wraps at 8000.
- R3: A packet counts as aged only when the deadline is strictly earlier than `cycle_time`. When `cycle_time` equals the deadline, the packet is not aged.
- R4: Both orderings are taken modulo the 24,576,000-tick period with the half-period rule, so a deadline or stamp just across the count wrap is ordered correctly.
- R5: `pkt_flush` is a one-clock pulse, raised in the clock after the aging decision. That pulse also discards the head packet, so in the following clock both outputs are low.
- R6: A clock with `pkt_valid` and `pkt_read` both high suppresses the flush for that packet. In the next clock `pkt_release` is low.
- R7: Aging is active only when `age_en` is 1 and `rx_offset` is nonzero. Otherwise `pkt_flush` stays low, while release still works.
- R8: While `rst_n` is low, both outputs are low.
- R9: One clock after a clock with `pkt_valid` low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| age_en | input | 1 | Enables aging |
| rx_stamp | input | 25 | Head packet receive stamp (count 24:12, ticks 11:0) |
| rx_offset | input | 25 | Receive offset, same format |
| cycle_time | input | 25 | Current bus cycle time, same format |
| pkt_valid | input | 1 | Buffer holds a head packet |
| pkt_read | input | 1 | Application consumes the head packet |
| pkt_release | output | 1 | Head packet may be read |
| pkt_flush | output | 1 | One-clock request to discard the head packet |

## Verification
A table of stamp, offset and cycle-time triples is applied. Each is sampled for release and flush.

- Pairs whose cycle time sits one tick either side of the stamp or the deadline separate "reached" from "not yet", and "equal" from "strictly past".
- Triples whose sum carries out of the tick field, out of the count field, or out of both at once check the mixed-radix adder.
- Cycle times just inside and just outside half a period from the stamp check the wrap rule.

Directed sequences then cover the following:
- a read in the deciding clock;
- a held aged packet, which must flush only once;
- release clearing on a read;
- the aging-disabled and zero-offset cases, where release alone must still appear.

// File: rtl/rxage_pkg.sv
package rxage_pkg;
  localparam int unsigned TICK_W_DEF   = 12;
  localparam int unsigned CYC_W_DEF    = 13;
  localparam int unsigned TICK_MOD_DEF = 3072;
  localparam int unsigned CYC_MOD_DEF  = 8000;

  typedef enum logic [1:0] {
    PK_EMPTY = 2'd0,
    PK_WAIT  = 2'd1,
    PK_READY = 2'd2
  } pk_state_e;
endpackage

// File: rtl/rxage_mradd.sv
// Mixed-radix add of two bus times: ticks carry into the count at TICK_MOD,
// the count wraps at CYC_MOD (the carry out of the count is dropped).
module rxage_mradd #(
  parameter int unsigned TICK_W   = rxage_pkg::TICK_W_DEF,
  parameter int unsigned CYC_W    = rxage_pkg::CYC_W_DEF,
  parameter int unsigned TICK_MOD = rxage_pkg::TICK_MOD_DEF,
  parameter int unsigned CYC_MOD  = rxage_pkg::CYC_MOD_DEF
) (
  input  logic [CYC_W+TICK_W-1:0] base_ts,
  input  logic [CYC_W+TICK_W-1:0] delta_ts,
  output logic [CYC_W+TICK_W-1:0] sum_ts
);
  localparam logic [TICK_W:0] TICK_LIM = (TICK_W+1)'(TICK_MOD);
  localparam logic [CYC_W:0]  CYC_LIM  = (CYC_W+1)'(CYC_MOD);

  logic [TICK_W:0]   tick_raw;
  logic [TICK_W:0]   tick_adj;
  logic              tick_carry;
  logic [CYC_W:0]    cyc_raw;
  logic [CYC_W:0]    cyc_adj;

  always_comb begin
    tick_raw   = {1'b0, base_ts[TICK_W-1:0]} + {1'b0, delta_ts[TICK_W-1:0]};
    tick_carry = (tick_raw >= TICK_LIM);
    tick_adj   = tick_carry ? (tick_raw - TICK_LIM) : tick_raw;

    cyc_raw = {1'b0, base_ts[TICK_W +: CYC_W]} + {1'b0, delta_ts[TICK_W +: CYC_W]}
            + {{CYC_W{1'b0}}, tick_carry};
    cyc_adj = (cyc_raw >= CYC_LIM) ? (cyc_raw - CYC_LIM) : cyc_raw;

    sum_ts = {cyc_adj[CYC_W-1:0], tick_adj[TICK_W-1:0]};
  end
endmodule

// File: rtl/rxage_wrapcmp.sv
// Orders two bus times on the wrapping timer: now_ts is "after" ref_ts when
// it lies less than half a period ahead. STRICT selects whether equal counts.
module rxage_wrapcmp #(
  parameter int unsigned TICK_W   = rxage_pkg::TICK_W_DEF,
  parameter int unsigned CYC_W    = rxage_pkg::CYC_W_DEF,
  parameter int unsigned TICK_MOD = rxage_pkg::TICK_MOD_DEF,
  parameter int unsigned CYC_MOD  = rxage_pkg::CYC_MOD_DEF,
  parameter bit          STRICT   = 1'b0
) (
  input  logic [CYC_W+TICK_W-1:0] now_ts,
  input  logic [CYC_W+TICK_W-1:0] ref_ts,
  output logic                    hit
);
  localparam int unsigned PERIOD = CYC_MOD * TICK_MOD;
  localparam int unsigned LIN_W  = $clog2(PERIOD);
  localparam logic [LIN_W:0] PERIOD_V = (LIN_W+1)'(PERIOD);
  localparam logic [LIN_W:0] HALF_V   = (LIN_W+1)'(PERIOD / 2);
  localparam logic [LIN_W:0] MULT_V   = (LIN_W+1)'(TICK_MOD);

  logic [LIN_W:0] now_lin;
  logic [LIN_W:0] ref_lin;
  logic [LIN_W:0] ahead;
  logic           within_half;

  always_comb begin
    now_lin = ((LIN_W+1)'(now_ts[TICK_W +: CYC_W]) * MULT_V)
            + (LIN_W+1)'(now_ts[TICK_W-1:0]);
    ref_lin = ((LIN_W+1)'(ref_ts[TICK_W +: CYC_W]) * MULT_V)
            + (LIN_W+1)'(ref_ts[TICK_W-1:0]);
    if (now_lin >= ref_lin) ahead = now_lin - ref_lin;
    else                    ahead = (now_lin + PERIOD_V) - ref_lin;
    within_half = (ahead < HALF_V);
  end

  generate
    if (STRICT) begin : g_strict
      assign hit = within_half && (ahead != '0);
    end else begin : g_inclusive
      assign hit = within_half;
    end
  endgenerate
endmodule

// File: rtl/rxage_seq.sv
// Per-packet state: release tracking and the registered flush pulse.
module rxage_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_valid,
  input  logic pkt_read,
  input  logic stamp_reached,
  input  logic deadline_passed,
  input  logic age_act,
  output logic release_o,
  output logic flush_o
);
  import rxage_pkg::*;

  pk_state_e st_q;
  pk_state_e st_d;
  logic      st_en;
  logic      flush_q;
  logic      flush_d;
  logic      pop;

  always_comb begin
    pop     = (pkt_valid && pkt_read) || flush_q;
    flush_d = age_act && pkt_valid && deadline_passed && !pkt_read && !flush_q;

    st_d = st_q;
    if (!pkt_valid || pop)     st_d = PK_EMPTY;
    else if (stamp_reached)    st_d = PK_READY;
    else if (st_q == PK_EMPTY) st_d = PK_WAIT;
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PK_EMPTY;
      flush_q <= 1'b0;
    end else begin
      if (st_en) st_q <= st_d;
      flush_q <= flush_d;
    end
  end

  assign release_o = (st_q == PK_READY);
  assign flush_o   = flush_q;
endmodule

// File: rtl/rxage_guard.sv
module rxage_guard #(
  parameter int unsigned TICK_W   = rxage_pkg::TICK_W_DEF,
  parameter int unsigned CYC_W    = rxage_pkg::CYC_W_DEF,
  parameter int unsigned TICK_MOD = rxage_pkg::TICK_MOD_DEF,
  parameter int unsigned CYC_MOD  = rxage_pkg::CYC_MOD_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    age_en,
  input  logic [CYC_W+TICK_W-1:0] rx_stamp,
  input  logic [CYC_W+TICK_W-1:0] rx_offset,
  input  logic [CYC_W+TICK_W-1:0] cycle_time,
  input  logic                    pkt_valid,
  input  logic                    pkt_read,
  output logic                    pkt_release,
  output logic                    pkt_flush
);
  localparam int unsigned TS_W = CYC_W + TICK_W;

  logic [1:0]      rst_pipe_q;
  logic            core_rst_n;
  logic [TS_W-1:0] deadline;
  logic            stamp_reached;
  logic            deadline_passed;
  logic            age_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  assign age_act = age_en && (rx_offset != '0);

  rxage_mradd #(.TICK_W(TICK_W), .CYC_W(CYC_W), .TICK_MOD(TICK_MOD), .CYC_MOD(CYC_MOD))
    u_sum (.base_ts(rx_stamp), .delta_ts(rx_offset), .sum_ts(deadline));

  rxage_wrapcmp #(.TICK_W(TICK_W), .CYC_W(CYC_W), .TICK_MOD(TICK_MOD), .CYC_MOD(CYC_MOD),
                  .STRICT(1'b0))
    u_rel_cmp (.now_ts(cycle_time), .ref_ts(rx_stamp), .hit(stamp_reached));

  rxage_wrapcmp #(.TICK_W(TICK_W), .CYC_W(CYC_W), .TICK_MOD(TICK_MOD), .CYC_MOD(CYC_MOD),
                  .STRICT(1'b1))
    u_age_cmp (.now_ts(cycle_time), .ref_ts(deadline), .hit(deadline_passed));

  rxage_seq u_seq (
    .clk             (clk),
    .rst_n           (core_rst_n),
    .pkt_valid       (pkt_valid),
    .pkt_read        (pkt_read),
    .stamp_reached   (stamp_reached),
    .deadline_passed (deadline_passed),
    .age_act         (age_act),
    .release_o       (pkt_release),
    .flush_o         (pkt_flush)
  );
endmodule

// File: rtl/rxage_guard_sva.sv
module rxage_guard_sva #(
  parameter int unsigned TICK_W   = rxage_pkg::TICK_W_DEF,
  parameter int unsigned CYC_W    = rxage_pkg::CYC_W_DEF,
  parameter int unsigned TICK_MOD = rxage_pkg::TICK_MOD_DEF,
  parameter int unsigned CYC_MOD  = rxage_pkg::CYC_MOD_DEF
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    age_en,
  input logic [CYC_W+TICK_W-1:0] rx_stamp,
  input logic [CYC_W+TICK_W-1:0] rx_offset,
  input logic [CYC_W+TICK_W-1:0] deadline,
  input logic                    deadline_passed,
  input logic                    pkt_valid,
  input logic                    pkt_read,
  input logic                    pkt_release,
  input logic                    pkt_flush
);
  logic fields_ok;
  assign fields_ok = (rx_stamp[TICK_W-1:0] < TICK_W'(TICK_MOD))
                  && (rx_stamp[TICK_W +: CYC_W] < CYC_W'(CYC_MOD))
                  && (rx_offset[TICK_W-1:0] < TICK_W'(TICK_MOD))
                  && (rx_offset[TICK_W +: CYC_W] < CYC_W'(CYC_MOD));

  assert_deadline_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fields_ok |-> ((deadline[TICK_W-1:0] < TICK_W'(TICK_MOD))
                && (deadline[TICK_W +: CYC_W] < CYC_W'(CYC_MOD))));

  assert_flush_after_deadline_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_flush |-> $past(deadline_passed));

  assert_flush_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_flush |=> !pkt_flush);

  assert_flush_not_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_flush |-> $past(pkt_valid && !pkt_read));

  assert_release_drop_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_read) |=> !pkt_release);

  assert_flush_needs_aging_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_flush |-> $past(age_en && (rx_offset != '0)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (!pkt_release && !pkt_flush));
endmodule

bind rxage_guard rxage_guard_sva #(
  .TICK_W(TICK_W), .CYC_W(CYC_W), .TICK_MOD(TICK_MOD), .CYC_MOD(CYC_MOD)
) u_sva (
  .clk(clk), .rst_n(rst_n), .age_en(age_en), .rx_stamp(rx_stamp),
  .rx_offset(rx_offset), .deadline(deadline), .deadline_passed(deadline_passed),
  .pkt_valid(pkt_valid), .pkt_read(pkt_read), .pkt_release(pkt_release),
  .pkt_flush(pkt_flush)
);

// File: tb/rxage_guard_test.sv
module rxage_guard_test;
  logic        clk;
  logic        rst_n;
  logic        age_en;
  logic [24:0] rx_stamp;
  logic [24:0] rx_offset;
  logic [24:0] cycle_time;
  logic        pkt_valid;
  logic        pkt_read;
  logic        pkt_release;
  logic        pkt_flush;

  int n_checks = 0;
  int n_fail   = 0;

  rxage_guard uut (
    .clk(clk), .rst_n(rst_n), .age_en(age_en), .rx_stamp(rx_stamp),
    .rx_offset(rx_offset), .cycle_time(cycle_time), .pkt_valid(pkt_valid),
    .pkt_read(pkt_read), .pkt_release(pkt_release), .pkt_flush(pkt_flush)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        en;
    logic [24:0] stamp;
    logic [24:0] off;
    logic [24:0] now;
    logic        rel;
    logic        fl;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, {13'd100, 12'd0},    {13'd0, 12'd500}, {13'd100, 12'd0},    1'b1, 1'b0},
    '{1'b1, {13'd100, 12'd0},    {13'd0, 12'd500}, {13'd99, 12'd3071},  1'b0, 1'b0},
    '{1'b1, {13'd100, 12'd0},    {13'd0, 12'd500}, {13'd100, 12'd501},  1'b1, 1'b1},
    '{1'b1, {13'd100, 12'd0},    {13'd0, 12'd500}, {13'd100, 12'd500},  1'b1, 1'b0},
    '{1'b1, {13'd10, 12'd3000},  {13'd0, 12'd100}, {13'd11, 12'd28},    1'b1, 1'b0},
    '{1'b1, {13'd10, 12'd3000},  {13'd0, 12'd100}, {13'd11, 12'd29},    1'b1, 1'b1},
    '{1'b1, {13'd7999, 12'd3000},{13'd0, 12'd100}, {13'd0, 12'd20},     1'b1, 1'b0},
    '{1'b1, {13'd7999, 12'd3000},{13'd0, 12'd100}, {13'd0, 12'd29},     1'b1, 1'b1},
    '{1'b1, {13'd7990, 12'd0},   {13'd20, 12'd0},  {13'd9, 12'd3071},   1'b1, 1'b0},
    '{1'b1, {13'd7990, 12'd0},   {13'd20, 12'd0},  {13'd10, 12'd1},     1'b1, 1'b1},
    '{1'b0, {13'd100, 12'd0},    {13'd0, 12'd500}, {13'd100, 12'd501},  1'b1, 1'b0},
    '{1'b1, {13'd100, 12'd0},    {13'd0, 12'd0},   {13'd100, 12'd5},    1'b1, 1'b0},
    '{1'b1, {13'd100, 12'd0},    {13'd0, 12'd500}, {13'd4200, 12'd0},   1'b0, 1'b0},
    '{1'b1, {13'd100, 12'd0},    {13'd0, 12'd500}, {13'd4099, 12'd0},   1'b1, 1'b1},
    '{1'b1, {13'd7999, 12'd3071},{13'd0, 12'd1},   {13'd0, 12'd1},      1'b1, 1'b1}
  };
  localparam string TAGS [NV] = '{
    "R1", "R1", "R3", "R3", "R2", "R2", "R4", "R4",
    "R2", "R2", "R7", "R7", "R4", "R4", "R2"
  };

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic load(input vec_t v, input logic rd);
    age_en     = v.en;
    rx_stamp   = v.stamp;
    rx_offset  = v.off;
    cycle_time = v.now;
    pkt_valid  = 1'b1;
    pkt_read   = rd;
  endtask

  task automatic gap();
    pkt_valid = 1'b0;
    pkt_read  = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; age_en = 1'b0; rx_stamp = '0; rx_offset = '0;
    cycle_time = '0; pkt_valid = 1'b0; pkt_read = 1'b0;
    repeat (3) @(negedge clk);
    pkt_valid = 1'b1; age_en = 1'b1;
    load(VECS[2], 1'b0);
    @(negedge clk);
    check("R8", "release in reset", pkt_release, 1'b0);
    check("R8", "flush in reset", pkt_flush, 1'b0);
    pkt_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      gap();
      load(VECS[i], 1'b0);
      @(negedge clk);
      check(TAGS[i], $sformatf("release vec %0d", i), pkt_release, VECS[i].rel);
      check(TAGS[i], $sformatf("flush vec %0d", i), pkt_flush, VECS[i].fl);
    end

    // R6: read in the deciding clock suppresses the flush
    gap();
    load(VECS[2], 1'b1);
    @(negedge clk);
    check("R6", "flush with read", pkt_flush, 1'b0);
    check("R6", "release after read", pkt_release, 1'b0);

    // R5: held aged packet flushes once, then head counts as discarded
    gap();
    load(VECS[2], 1'b0);
    @(negedge clk);
    check("R5", "first flush", pkt_flush, 1'b1);
    @(negedge clk);
    check("R5", "flush second clock", pkt_flush, 1'b0);
    check("R5", "release after flush", pkt_release, 1'b0);

    // R6: release clears on read, returns for next (reached) packet
    gap();
    load(VECS[0], 1'b0);
    @(negedge clk);
    check("R1", "release held pkt", pkt_release, 1'b1);
    pkt_read = 1'b1;
    @(negedge clk);
    check("R6", "release after read", pkt_release, 1'b0);
    pkt_read = 1'b0;
    @(negedge clk);
    check("R1", "release next pkt", pkt_release, 1'b1);

    // R9: valid low clears outputs
    load(VECS[2], 1'b0);
    pkt_valid = 1'b0;
    @(negedge clk);
    check("R9", "release idle", pkt_release, 1'b0);
    check("R9", "flush idle", pkt_flush, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule